// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Switch Controller

This block sits between a processor's write path and the program and character ROMs of a cartridge. It holds four five-bit configuration registers: a control word, two character-bank numbers and one program-bank number. The processor cannot write a register in a single access. Each write carries one data bit, and five consecutive writes to the same address region fill one register. Address bits 14 and 13 choose the target register. A write with bit 7 set abandons a partial load. So does a write aimed at a different register from the one being filled.

The registers are decoded into bank numbers. Two 16 KB program windows sit at $8000 and $C000. Two 4 KB character windows sit at $0000 and $1000. A mirroring mode is also produced for the nametable logic. The program window can switch as one 32 KB unit, or one 16 KB window can switch while the other stays fixed. The character windows can switch as one 8 KB pair or as two independent 4 KB banks.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset, prg_lo_bank is 0, prg_hi_bank is the last bank (all ones, 15 at default width), chr_lo_bank is 0, chr_hi_bank is 1 and mirror_mode is 2'b00.
- R2: A register is loaded by five accepted writes to the same region. Bit 0 of each write is taken, and the first write becomes register bit 0. The new value appears on the outputs in the cycle after the fifth write and not earlier.
- R3: An accepted write with bit 7 set discards any partial load, so the next write becomes bit 0. It also sets control bits 3 and 2 to 1 and leaves all other register bits unchanged.
- R4: While a load is partial, a write to a different region discards it. That write becomes bit 0 of a new load into its own region, and the register of the abandoned region keeps its value.
- R5: addr_sel selects the register: 0 is control, 1 is character bank A, 2 is character bank B and 3 is the program bank.
- R6: When control bit 3 is 0 (32 KB mode), prg_lo_bank is the program value with bit 0 cleared and prg_hi_bank is that value plus one.
- R7: When control bit 3 is 1 and control bit 2 is 1, prg_lo_bank follows the program value and prg_hi_bank is the last bank.
- R8: When control bit 3 is 1 and control bit 2 is 0, prg_lo_bank is 0 and prg_hi_bank follows the program value.
- R9: When control bit 4 is 0, chr_lo_bank is character bank A (n) and chr_hi_bank is n+1 modulo 32.
- R10: When control bit 4 is 1, chr_lo_bank is character bank A and chr_hi_bank is character bank B.
- R11: mirror_mode is 2'b00 (single screen) when control bit 1 is 0. Otherwise it is 2'b10 (horizontal) when control bit 0 is 0 and 2'b11 (vertical) when control bit 0 is 1.
- R12: Cycles with wr_en low do not advance a load, and data bits 6 to 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe from the processor |
| addr_sel | input | 2 | Address bits 14:13 of the write, selecting the register |
| wr_data | input | 8 | Write data; bit 0 is the serial bit, bit 7 clears the load |
| prg_lo_bank | output | PRG_W | 16 KB program bank mapped at $8000 |
| prg_hi_bank | output | PRG_W | 16 KB program bank mapped at $C000 |
| chr_lo_bank | output | 5 | 4 KB character bank mapped at $0000 |
| chr_hi_bank | output | 5 | 4 KB character bank mapped at $1000 |
| mirror_mode | output | 2 | 00 single screen, 10 horizontal, 11 vertical |

## Verification
A shift counter that drifts by one shows up as a register value that commits one write early or late. The load is then shifted or truncated, and the bank outputs show it in the cycle after the misplaced write. A stale target tag or a missed clear shows up as a commit before the fifth write of the following load, so the bench samples the outputs partway through loads as well as at their end. Faults in the decode show up at once as a wrong bank pair or mirroring code whenever the affected control mode is selected.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

    localparam int REG_W = 5;
    localparam int CNT_W = $clog2(REG_W + 1);

    typedef logic [REG_W-1:0] regval_t;
    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [1:0] {
        TGT_CTRL   = 2'd0,
        TGT_CHR_A  = 2'd1,
        TGT_CHR_B  = 2'd2,
        TGT_PRG    = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        MIR_SINGLE = 2'b00,
        MIR_RSV    = 2'b01,
        MIR_HORZ   = 2'b10,
        MIR_VERT   = 2'b11
    } mirror_e;

    // Control word, MSB first: bit4 .. bit0
    typedef struct packed {
        logic chr_split;    // 1: two independent 4 KB character banks
        logic prg_16k;      // 1: 16 KB program switching
        logic prg_lo_swap;  // 1: $8000 window swappable, $C000 fixed last
        logic mir_multi;    // 0: single screen
        logic mir_vert;     // 1: vertical, 0: horizontal
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{chr_split: 1'b0, prg_16k: 1'b1,
                                     prg_lo_swap: 1'b1, mir_multi: 1'b0,
                                     mir_vert: 1'b0};

    typedef struct packed {
        logic    valid;
        tgt_e    tgt;
        regval_t value;
    } commit_t;

    function automatic mirror_e decode_mirror(input ctrl_t c);
        if (!c.mir_multi)
            return MIR_SINGLE;
        return c.mir_vert ? MIR_VERT : MIR_HORZ;
    endfunction

endpackage

// File: rtl/sbank_loader.sv
module sbank_loader
    import sbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  tgt_e    wr_tgt,
    input  logic    wr_bit,
    input  logic    wr_clear,
    output commit_t commit,
    output logic    clear_pulse
);

    localparam count_t LAST_POS = count_t'(REG_W - 1);

    regval_t sr_q;
    count_t  cnt_q;
    tgt_e    tgt_q;

    logic    restart;
    regval_t base;
    count_t  cnt_eff;
    regval_t shifted;
    logic    accept;

    always_comb begin
        accept  = wr_en && !wr_clear;
        restart = (cnt_q != '0) && (wr_tgt != tgt_q);
        base    = restart ? '0 : sr_q;
        cnt_eff = restart ? '0 : cnt_q;
        shifted = {wr_bit, base[REG_W-1:1]};
    end

    always_comb begin
        commit.valid = accept && (cnt_eff == LAST_POS);
        commit.tgt   = wr_tgt;
        commit.value = shifted;
        clear_pulse  = wr_en && wr_clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
            tgt_q <= TGT_CTRL;
        end else if (clear_pulse) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            tgt_q <= wr_tgt;
            if (cnt_eff == LAST_POS) begin
                sr_q  <= '0;
                cnt_q <= '0;
            end else begin
                sr_q  <= shifted;
                cnt_q <= cnt_eff + 1'b1;
            end
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_POS);

    p_clear_empties_r3: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |=> (cnt_q == '0));

    p_retarget_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && (cnt_q != '0) && (wr_tgt != tgt_q)) |=> (cnt_q == count_t'(1)));

    p_idle_holds_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cnt_q) && $stable(sr_q));

endmodule

// File: rtl/sbank_regs.sv
module sbank_regs
    import sbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  commit_t commit,
    input  logic    clear_pulse,
    output ctrl_t   ctrl_q,
    output regval_t chr_a_q,
    output regval_t chr_b_q,
    output regval_t prg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RESET;
            chr_a_q <= '0;
            chr_b_q <= '0;
            prg_q   <= '0;
        end else if (clear_pulse) begin
            ctrl_q.prg_16k     <= 1'b1;
            ctrl_q.prg_lo_swap <= 1'b1;
        end else if (commit.valid) begin
            case (commit.tgt)
                TGT_CTRL:  ctrl_q  <= ctrl_t'(commit.value);
                TGT_CHR_A: chr_a_q <= commit.value;
                TGT_CHR_B: chr_b_q <= commit.value;
                TGT_PRG:   prg_q   <= commit.value;
                default:   ;
            endcase
        end
    end

    p_clear_mode_r3: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |=> (ctrl_q.prg_16k && ctrl_q.prg_lo_swap));

    p_prg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(commit.valid && commit.tgt == TGT_PRG) |=> $stable(prg_q));

    p_chr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(commit.valid && commit.tgt == TGT_CHR_B) |=> $stable(chr_b_q));

endmodule

// File: rtl/sbank_map.sv
module sbank_map
    import sbank_pkg::*;
#(
    parameter int PRG_W = 4
) (
    input  ctrl_t            ctrl_q,
    input  regval_t          chr_a_q,
    input  regval_t          chr_b_q,
    input  regval_t          prg_q,
    output logic [PRG_W-1:0] prg_lo_bank,
    output logic [PRG_W-1:0] prg_hi_bank,
    output regval_t          chr_lo_bank,
    output regval_t          chr_hi_bank,
    output mirror_e          mirror_mode
);

    localparam logic [PRG_W-1:0] PRG_LAST = '1;

    logic [PRG_W-1:0] prg_sel;

    generate
        if (PRG_W <= REG_W) begin : g_prg_trunc
            assign prg_sel = prg_q[PRG_W-1:0];
        end else begin : g_prg_pad
            assign prg_sel = {{(PRG_W-REG_W){1'b0}}, prg_q};
        end
    endgenerate

    always_comb begin
        if (!ctrl_q.prg_16k) begin
            prg_lo_bank = {prg_sel[PRG_W-1:1], 1'b0};
            prg_hi_bank = {prg_sel[PRG_W-1:1], 1'b1};
        end else if (ctrl_q.prg_lo_swap) begin
            prg_lo_bank = prg_sel;
            prg_hi_bank = PRG_LAST;
        end else begin
            prg_lo_bank = '0;
            prg_hi_bank = prg_sel;
        end
    end

    always_comb begin
        chr_lo_bank = chr_a_q;
        chr_hi_bank = ctrl_q.chr_split ? chr_b_q : chr_a_q + 1'b1;
        mirror_mode = decode_mirror(ctrl_q);
    end

endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
    import sbank_pkg::*;
#(
    parameter int PRG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr_sel,
    input  logic [7:0]       wr_data,
    output logic [PRG_W-1:0] prg_lo_bank,
    output logic [PRG_W-1:0] prg_hi_bank,
    output logic [4:0]       chr_lo_bank,
    output logic [4:0]       chr_hi_bank,
    output logic [1:0]       mirror_mode
);

    commit_t commit;
    logic    clear_pulse;
    ctrl_t   ctrl_q;
    regval_t chr_a_q, chr_b_q, prg_q;
    regval_t chr_lo_w, chr_hi_w;
    mirror_e mirror_w;

    sbank_loader u_loader (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_tgt      (tgt_e'(addr_sel)),
        .wr_bit      (wr_data[0]),
        .wr_clear    (wr_data[7]),
        .commit      (commit),
        .clear_pulse (clear_pulse)
    );

    sbank_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .clear_pulse (clear_pulse),
        .ctrl_q      (ctrl_q),
        .chr_a_q     (chr_a_q),
        .chr_b_q     (chr_b_q),
        .prg_q       (prg_q)
    );

    sbank_map #(.PRG_W(PRG_W)) u_map (
        .ctrl_q      (ctrl_q),
        .chr_a_q     (chr_a_q),
        .chr_b_q     (chr_b_q),
        .prg_q       (prg_q),
        .prg_lo_bank (prg_lo_bank),
        .prg_hi_bank (prg_hi_bank),
        .chr_lo_bank (chr_lo_w),
        .chr_hi_bank (chr_hi_w),
        .mirror_mode (mirror_w)
    );

    assign chr_lo_bank = chr_lo_w;
    assign chr_hi_bank = chr_hi_w;
    assign mirror_mode = mirror_w;

    p_pair_adjacent_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.prg_16k |-> (prg_hi_bank == prg_lo_bank + 1'b1) && !prg_lo_bank[0]);

    p_last_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.prg_16k && ctrl_q.prg_lo_swap) |-> (prg_hi_bank == '1));

    p_first_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.prg_16k && !ctrl_q.prg_lo_swap) |-> (prg_lo_bank == '0));

    p_single_screen_r11: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.mir_multi |-> (mirror_mode == 2'b00));

endmodule

// File: tb/sim_serial_bank_ctrl.sv
module sim_serial_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PRG_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       addr_sel = 2'd0;
    logic [7:0]       wr_data = 8'd0;
    logic [PRG_W-1:0] prg_lo_bank, prg_hi_bank;
    logic [4:0]       chr_lo_bank, chr_hi_bank;
    logic [1:0]       mirror_mode;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_bank_ctrl #(.PRG_W(PRG_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr_sel(addr_sel),
        .wr_data(wr_data), .prg_lo_bank(prg_lo_bank), .prg_hi_bank(prg_hi_bank),
        .chr_lo_bank(chr_lo_bank), .chr_hi_bank(chr_hi_bank),
        .mirror_mode(mirror_mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'd0;
    endtask

    // one serial bit; bits 6:1 carry noise that must be ignored (R12)
    task automatic wr_bit(input logic [1:0] s, input logic b);
        wr(s, {1'b0, 6'b101101, b});
    endtask

    task automatic load(input logic [1:0] s, input logic [4:0] v);
        for (int i = 0; i < 5; i++) wr_bit(s, v[i]);
    endtask

    task automatic t_reset();
        chk("R1 prg_lo", prg_lo_bank, 0);
        chk("R1 prg_hi", prg_hi_bank, 15);
        chk("R1 chr_lo", chr_lo_bank, 0);
        chk("R1 chr_hi", chr_hi_bank, 1);
        chk("R1 mirror", mirror_mode, 0);
    endtask

    task automatic t_serial();
        logic [4:0] v = 5'd5;
        for (int i = 0; i < 4; i++) wr_bit(2'd3, v[i]);
        chk("R2 no early commit", prg_lo_bank, 0);
        wr_bit(2'd3, v[4]);
        chk("R2 R5 prg after fifth", prg_lo_bank, 5);
        chk("R7 last fixed", prg_hi_bank, 15);
    endtask

    task automatic t_idle();
        logic [4:0] v = 5'd7;
        for (int i = 0; i < 4; i++) wr_bit(2'd1, v[i]);
        @(negedge clk); addr_sel = 2'd3; wr_data = 8'hFF;
        repeat (3) @(negedge clk);
        wr_data = 8'd0;
        chk("R12 idle no commit", chr_lo_bank, 0);
        wr_bit(2'd1, v[4]);
        chk("R12 R5 chr A after idle", chr_lo_bank, 7);
        chk("R9 chr pair", chr_hi_bank, 8);
        load(2'd1, 5'd31);
        chk("R9 wrap lo", chr_lo_bank, 31);
        chk("R9 wrap hi", chr_hi_bank, 0);
    endtask

    task automatic t_modes();
        load(2'd0, 5'b11111);
        chk("R11 vertical", mirror_mode, 3);
        chk("R10 split hi", chr_hi_bank, 0);
        load(2'd2, 5'd9);
        chk("R10 split lo", chr_lo_bank, 31);
        chk("R10 R5 chr B", chr_hi_bank, 9);
        load(2'd0, 5'b11110);
        chk("R11 horizontal", mirror_mode, 2);
        load(2'd0, 5'b11101);
        chk("R11 single", mirror_mode, 0);
        load(2'd0, 5'b11001);
        chk("R8 lo fixed", prg_lo_bank, 0);
        chk("R8 hi swap", prg_hi_bank, 5);
        load(2'd0, 5'b10011);
        chk("R6 lo even", prg_lo_bank, 4);
        chk("R6 hi odd", prg_hi_bank, 5);
        load(2'd3, 5'd10);
        chk("R6 lo", prg_lo_bank, 10);
        chk("R6 hi", prg_hi_bank, 11);
    endtask

    task automatic t_clear();
        logic [4:0] v = 5'd3;
        wr_bit(2'd3, 1'b1); wr_bit(2'd3, 1'b1); wr_bit(2'd3, 1'b1);
        wr(2'd3, 8'h80);
        chk("R3 mode forced lo", prg_lo_bank, 10);
        chk("R3 mode forced hi", prg_hi_bank, 15);
        chk("R3 mirror kept", mirror_mode, 3);
        wr_bit(2'd3, v[0]); wr_bit(2'd3, v[1]);
        chk("R3 partial discarded", prg_lo_bank, 10);
        wr_bit(2'd3, v[2]); wr_bit(2'd3, v[3]); wr_bit(2'd3, v[4]);
        chk("R3 fresh load", prg_lo_bank, 3);
    endtask

    task automatic t_retarget();
        logic [4:0] v = 5'd6;
        wr_bit(2'd2, 1'b1); wr_bit(2'd2, 1'b1); wr_bit(2'd2, 1'b1);
        wr_bit(2'd3, v[0]); wr_bit(2'd3, v[1]);
        chk("R4 restart no commit", prg_lo_bank, 3);
        chk("R4 old target kept", chr_hi_bank, 9);
        wr_bit(2'd3, v[2]); wr_bit(2'd3, v[3]); wr_bit(2'd3, v[4]);
        chk("R4 new load", prg_lo_bank, 6);
        chk("R4 old target still", chr_hi_bank, 9);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_serial();
        t_idle();
        t_modes();
        t_clear();
        t_retarget();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule